// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Mode Selector

This block sits beside the clock generator core. During power-up it treats a shared pad as an input and records its level as the upper frequency-select bit. After a programmable number of timer ticks, it takes the pad over as an output that carries the reference clock. From then on the recorded bit is frozen until the next power-on reset.

Two more pins choose the operating mode. One is an active-low tristate control and the other is the lower select bit. There are three modes:

- **Normal:** the block reports a two-bit frequency code for the PLL stage, which lies outside this block. The group clock outputs stay low, with their enables on.
- **Output-disable:** every output enable, including the pad's, is dropped.
- **Test:** an external test clock arrives on the crystal input. The block divides it by a fixed ratio for each output group, and the reference pad carries the test clock undivided.

The crystal/test input is oversampled by the core clock. Each detected rising edge advances the dividers.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While reset is asserted, `pin_oe`, `grp_oe` and `grp_clk` are all 0, `freq_code` is 0 and `mode` reads output-disable (1).
- R2: `pin_oe` stays 0 until `PWRUP_TICKS` cycles with `tick` high have been seen since reset. It rises in the cycle after the clock edge that registers the last of those ticks, unless the mode is output-disable.
- R3: The strap bit is the level of `pin_in` on the clock edge that registers the final power-up tick. Its level at earlier ticks has no effect.
- R4: After capture, changes on `pin_in` leave the strap (bit 1 of `freq_code`) unchanged until the next reset.
- R5: When `tri_n`=0 and `sel0`=0, the mode is output-disable (code 1): `grp_oe` is all 0 and `pin_oe` is 0.
- R6: When `tri_n`=0 and `sel0`=1, the mode is test (code 2). Outputs are in index order: 0 CPU, 1 memory, 2 66-MHz group, 3 PCI, 4 APIC, 5 48-MHz group. Their periods are 4, 4, 6, 12, 12 and 2 test-clock periods. `pin_out` follows the test clock with a period of 1.
- R7: When `tri_n`=1, the mode is normal (code 0) and `freq_code` = {strap, `sel0`}. The codes mean: 0 = 66 MHz CPU / 100 MHz memory, 1 = 100/100, 2 = 133/133, 3 = 133/100.
- R8: Test outputs have 50% duty. On entry to test mode they are all low. Their first rising edges coincide with the first rise of `pin_out`.
- R9: In normal mode `grp_clk` is all 0 and `grp_oe` is all 1.
- R10: `mode` and `freq_code` reflect `tri_n`/`sel0` one clock edge after those inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | One-cycle timer pulse for the power-up delay |
| pin_in | input | 1 | Level seen at the shared pad |
| pin_out | output | 1 | Reference/test clock driven onto the shared pad |
| pin_oe | output | 1 | Output enable of the shared pad |
| tri_n | input | 1 | Tristate control, low selects disable or test |
| sel0 | input | 1 | Lower frequency-select bit |
| xin | input | 1 | Crystal reference or test clock, oversampled |
| grp_clk | output | 6 | Per-group clock outputs |
| grp_oe | output | 6 | Per-group output enables |
| mode | output | 2 | 0 normal, 1 output-disable, 2 test |
| freq_code | output | 2 | {strap, sel0} frequency selection code |

## Verification
The assertions take certain properties of the inputs for granted:

- Every input is synchronous to `clk`.
- `tick` is a pulse.
- Each level of `xin` lasts at least one core cycle, so no test-clock edge is missed.
- Reset is released away from a clock edge.

The bench drives every input at falling edges. It holds `xin` for two core cycles per level, giving a test-clock period of four core cycles. It shortens the power-up delay to eight ticks so the strap timing can be probed tick by tick.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HIZ    = 2'd1,
    MODE_TEST   = 2'd2
  } mode_e;

  localparam int NGRP     = 6;
  localparam int GRP_CPU  = 0;
  localparam int GRP_MEM  = 1;
  localparam int GRP_66   = 2;
  localparam int GRP_PCI  = 3;
  localparam int GRP_APIC = 4;
  localparam int GRP_48   = 5;

  // test-mode division ratio per output group, in test-clock periods
  function automatic int grp_div(input int g);
    case (g)
      GRP_CPU, GRP_MEM:  return 4;
      GRP_66:            return 6;
      GRP_PCI, GRP_APIC: return 12;
      default:           return 2;
    endcase
  endfunction

endpackage

// File: rtl/powerup_strap.sv
module powerup_strap #(
  parameter int TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_in,
  output logic done,
  output logic strap
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      strap <= 1'b0;
    end else if (!done && tick) begin
      if (cnt == LAST) begin
        done  <= 1'b1;
        strap <= pin_in;   // sampled once, on the final tick
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mode_sel.sv
module mode_sel
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tri_n,
  input  logic       sel0,
  input  logic       strap,
  output mode_e      mode,
  output logic [1:0] freq_code
);
  mode_e nxt;

  always_comb begin
    if (tri_n)     nxt = MODE_NORMAL;
    else if (sel0) nxt = MODE_TEST;
    else           nxt = MODE_HIZ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_HIZ;
      freq_code <= 2'b00;
    end else begin
      mode      <= nxt;
      freq_code <= {strap, sel0};
    end
  end
endmodule

// File: rtl/test_div.sv
module test_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  output logic out
);
  localparam int HALF = (DIV > 1) ? DIV / 2 : 1;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      out <= 1'b0;
    end else if (rise) begin
      if (cnt == '0) out <= ~out;   // toggle on phase zero so all groups line up
      cnt <= (cnt == WRAP) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import smc_pkg::*;
#(
  parameter int PWRUP_TICKS = 2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  input  logic            tri_n,
  input  logic            sel0,
  input  logic            xin,
  output logic [NGRP-1:0] grp_clk,
  output logic [NGRP-1:0] grp_oe,
  output logic [1:0]      mode,
  output logic [1:0]      freq_code
);
  logic  done;
  logic  strap;
  mode_e mode_q;
  logic  xin_q;
  logic  xin_rise;
  logic  run;

  powerup_strap #(.TICKS(PWRUP_TICKS)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .pin_in(pin_in),
    .done  (done),
    .strap (strap)
  );

  mode_sel u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .tri_n    (tri_n),
    .sel0     (sel0),
    .strap    (strap),
    .mode     (mode_q),
    .freq_code(freq_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xin_q <= 1'b0;
    else        xin_q <= xin;
  end

  assign xin_rise = xin & ~xin_q;
  assign run      = (mode_q == MODE_TEST);

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    test_div #(.DIV(grp_div(g))) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .rise (xin_rise),
      .out  (grp_clk[g])
    );
  end

  assign grp_oe  = {NGRP{mode_q != MODE_HIZ}};
  assign pin_oe  = done && (mode_q != MODE_HIZ);
  assign pin_out = pin_oe & xin_q;
  assign mode    = mode_q;
endmodule

// File: rtl/strap_mode_chk.sv
module strap_mode_chk #(
  parameter int PWRUP_TICKS = 2000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tri_n,
  input logic       sel0,
  input logic       pin_oe,
  input logic [5:0] grp_clk,
  input logic [5:0] grp_oe,
  input logic [1:0] mode,
  input logic [1:0] freq_code
);
  logic [31:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  tcnt <= '0;
    else if (tick && tcnt < 32'(PWRUP_TICKS))    tcnt <= tcnt + 32'd1;
  end

  function automatic logic [1:0] dec(input logic t, input logic s);
    return t ? 2'd0 : (s ? 2'd2 : 2'd1);
  endfunction

  // R2
  pwrup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> tcnt >= 32'(PWRUP_TICKS));

  // R4
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pin_oe, 2) |-> $stable(freq_code[1]));

  // R5
  hiz_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (grp_oe == '0 && !pin_oe));

  // R9
  normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) == 2'd0) |-> (grp_clk == '0 && grp_oe == '1));

  // R6
  pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_clk[0] == grp_clk[1] && grp_clk[3] == grp_clk[4]);

  // R10
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> mode == dec($past(tri_n), $past(sel0)));
endmodule

bind strap_mode_ctrl strap_mode_chk #(.PWRUP_TICKS(PWRUP_TICKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .tri_n    (tri_n),
  .sel0     (sel0),
  .pin_oe   (pin_oe),
  .grp_clk  (grp_clk),
  .grp_oe   (grp_oe),
  .mode     (mode),
  .freq_code(freq_code)
);

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
  localparam int TCK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pin_in = 1'b0;
  logic tri_n = 1'b1;
  logic sel0 = 1'b0;
  logic xin = 1'b0;
  logic pin_out, pin_oe;
  logic [5:0] grp_clk, grp_oe;
  logic [1:0] mode, freq_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // {tri_n, sel0, strap, mode[1:0], freq[1:0]}
  localparam logic [6:0] VEC [8] = '{
    7'b000_01_00, 7'b001_01_10, 7'b010_10_01, 7'b011_10_11,
    7'b100_00_00, 7'b101_00_10, 7'b110_00_01, 7'b111_00_11 };
  localparam int DIVS [6] = '{4, 4, 6, 12, 12, 2};

  always #5 clk = ~clk;

  strap_mode_ctrl #(.PWRUP_TICKS(TCK)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tri_n(tri_n), .sel0(sel0),
    .xin(xin), .grp_clk(grp_clk), .grp_oe(grp_oe), .mode(mode),
    .freq_code(freq_code));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic t, input logic s, input logic p);
    @(negedge clk);
    rst_n = 1'b0; tri_n = t; sel0 = s; pin_in = p; tick = 1'b0; xin = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic give_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int first [7];
    int second [7];
    int highs [7];
    logic [6:0] prev;
    logic [6:0] cur;

    // R1: state under reset
    @(negedge clk); @(negedge clk);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 grp_oe", 32'(grp_oe), 0);
    chk("R1 grp_clk", 32'(grp_clk), 0);
    chk("R1 freq_code", 32'(freq_code), 0);
    chk("R1 mode", 32'(mode), 1);

    // table walk: R5 R7 R9 per row
    for (int i = 0; i < 8; i++) begin
      logic [6:0] v;
      v = VEC[i];
      do_reset(v[6], v[5], v[4]);
      give_ticks(TCK);
      @(negedge clk);
      chk("R7 freq_code", 32'(freq_code), 32'(v[1:0]));
      chk("R5 mode", 32'(mode), 32'(v[3:2]));
      chk("R2 pin_oe", 32'(pin_oe), 32'(v[3:2] != 2'd1));
      chk("R9 grp_oe", 32'(grp_oe), (v[3:2] == 2'd1) ? 0 : 32'h3f);
      chk("R9 grp_clk", 32'(grp_clk), 0);
    end

    // R2 / R3: pad held high through early ticks, low at last tick
    do_reset(1'b1, 1'b0, 1'b1);
    give_ticks(TCK - 1);
    @(negedge clk);
    chk("R2 pin_oe before last tick", 32'(pin_oe), 0);
    pin_in = 1'b0;
    give_ticks(1);
    chk("R2 pin_oe after last tick", 32'(pin_oe), 1);
    @(negedge clk);
    chk("R3 strap low", 32'(freq_code), 0);

    // R3: low during wait, high only at final tick
    do_reset(1'b1, 1'b0, 1'b0);
    give_ticks(TCK - 1);
    pin_in = 1'b1;
    give_ticks(1);
    @(negedge clk);
    chk("R3 strap high", 32'(freq_code), 2);

    // R4: later pad activity ignored
    pin_in = 1'b0;
    give_ticks(3);
    repeat (5) @(negedge clk);
    chk("R4 strap kept", 32'(freq_code[1]), 1);
    pin_in = 1'b1; @(negedge clk); pin_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 strap kept after toggle", 32'(freq_code[1]), 1);

    // R10: sel0 and tri_n changes, one edge later
    sel0 = 1'b1;
    @(negedge clk);
    chk("R10 freq_code", 32'(freq_code), 3);
    tri_n = 1'b0; sel0 = 1'b0;
    @(negedge clk);
    chk("R10 mode hiz", 32'(mode), 1);
    chk("R5 pin_oe off", 32'(pin_oe), 0);
    chk("R5 grp_oe off", 32'(grp_oe), 0);

    // R6 / R8: test mode division
    xin = 1'b0; sel0 = 1'b1;
    @(negedge clk);
    chk("R6 mode test", 32'(mode), 2);
    @(negedge clk);
    chk("R8 all low on entry", 32'(grp_clk), 0);
    chk("R6 pin_oe in test", 32'(pin_oe), 1);
    for (int g = 0; g < 7; g++) begin first[g] = -1; second[g] = -1; highs[g] = 0; end
    prev = '0;
    fork
      begin
        for (int k = 0; k < 60; k++) begin
          xin = ~xin;
          @(negedge clk);
          @(negedge clk);
        end
      end
      begin
        for (int c = 0; c < 120; c++) begin
          @(negedge clk);
          cur = {pin_out, grp_clk};
          for (int g = 0; g < 7; g++) begin
            if (cur[g] && !prev[g]) begin
              if (first[g] < 0) first[g] = c;
              else if (second[g] < 0) second[g] = c;
            end
            if (cur[g] && first[g] >= 0 && second[g] < 0) highs[g]++;
          end
          prev = cur;
        end
      end
    join
    chk("R6 pin_out period", 32'(second[6] - first[6]), 4);
    for (int g = 0; g < 6; g++) begin
      chk("R6 group period", 32'(second[g] - first[g]), 32'(DIVS[g] * 4));
      chk("R8 group duty", 32'(highs[g]), 32'(DIVS[g] * 2));
      chk("R8 first edge aligned", 32'(first[g]), 32'(first[6]));
    end

    // R9: back to normal, outputs quiet
    xin = 1'b0; tri_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 grp_clk quiet", 32'(grp_clk), 0);
    chk("R9 grp_oe on", 32'(grp_oe), 32'h3f);

    // R4: new power-on re-latches strap
    do_reset(1'b1, 1'b0, 1'b0);
    give_ticks(TCK);
    @(negedge clk);
    chk("R4 strap relatched", 32'(freq_code), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule